// File: doc/BRIEF.md
# Base and Bound Address Translator

This block turns the virtual address of each access a process makes into a physical address. It also checks that the access stays inside the region given to that process. Every process sees its own address space starting at zero. The block adds a per-process base value to the virtual address. Before that, it makes one unsigned comparison of the address against a size limit. No table is consulted.

A privileged configuration port loads the two values: the base, which is the start of the region in physical memory, and the bound, which is the size of the region. A request carries a virtual address and an access kind. The kind is an instruction fetch, a load or a store, and all three are translated the same way. One cycle after a request is accepted, a registered response comes back. It holds the physical address, a fault flag, the echoed kind and a memory-go strobe. The strobe tells the memory side whether to forward the access. The response is held under a valid/ready handshake.

Top module: `bb_xlate`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears base, bound and rsp_valid. With bound zero, the first request after reset faults.
- R2: For a legal access, rsp_paddr equals base plus the zero-extended virtual address, modulo 2^PA_W.
- R3: An access is legal only when the zero-extended virtual address is strictly less than bound, compared unsigned. Otherwise rsp_fault is 1.
- R4: When bound is zero, every access faults, including virtual address 0.
- R5: The access kinds are fetch=0, load=1 and store=2, with 3 treated like a load. All kinds are checked and relocated in the same way, and the kind of the request is returned on rsp_kind.
- R6: A faulting response drives rsp_paddr to 0. rsp_mem_go equals rsp_valid AND NOT rsp_fault, so no memory request goes out on a fault.
- R7: When cfg_we is 1 at a clock edge, cfg_data is written to base if cfg_sel is 0, or to bound if cfg_sel is 1. The new value is used from the next cycle on. A request accepted in the same cycle as the write uses the old values.
- R8: A request accepted at a clock edge (req_valid and req_ready both 1) has its response on the outputs right after that edge.
- R9: req_ready equals NOT rsp_valid OR rsp_ready. While rsp_valid is 1 and rsp_ready is 0, every response output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Privileged register write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 bound |
| cfg_data | input | PA_W | Value to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_vaddr | input | VA_W | Virtual address |
| req_kind | input | 2 | Access kind (0 fetch, 1 load, 2 store) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 1 | Out-of-region access |
| rsp_kind | output | 2 | Echoed access kind |
| rsp_mem_go | output | 1 | Forward access to memory |

## Verification
A base register holding the wrong value shows up as a wrong rsp_paddr on the very next legal response. A bound register holding the wrong value shows up as a wrong fault flag at the first address between the correct limit and the wrong one. The bench therefore probes addresses on both sides of the limit, right after each register write. A broken output register or handshake shows up within one cycle as a wrong rsp_valid, or as a change in the outputs during a stall. The bench compares every response port against its model on every cycle.

// File: rtl/bb_pkg.sv
// Shared types for the base/bound translator.
// Assumes nothing beyond a two-bit access kind code.
package bb_pkg;
    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_t;

    localparam logic SEL_BASE  = 1'b0;
    localparam logic SEL_BOUND = 1'b1;
endpackage

// File: rtl/bb_regs.sv
// Holds the per-process relocation base and region size.
// Assumes the write port is reachable only by privileged software.
// A write is visible on the cycle after it is accepted.
module bb_regs #(
    parameter int PA_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            sel,
    input  logic [PA_W-1:0] wdata,
    output logic [PA_W-1:0] base_q,
    output logic [PA_W-1:0] bound_q
);
    import bb_pkg::*;

    // Load base or bound on a write; clear both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            bound_q <= '0;
        end else if (we) begin
            if (sel == SEL_BASE) base_q  <= wdata;
            else                 bound_q <= wdata;
        end
    end
endmodule

// File: rtl/bb_calc.sv
// Combinational relocation and limit check.
// Assumes PA_W >= VA_W; the virtual address is zero-extended.
// A faulting access yields a zero physical address.
module bb_calc #(
    parameter int VA_W = 16,
    parameter int PA_W = 20
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [PA_W-1:0] base,
    input  logic [PA_W-1:0] bound,
    output logic [PA_W-1:0] paddr,
    output logic            fault
);
    logic [PA_W-1:0] va_ext;

    // Zero-extend, compare unsigned against the size, relocate.
    always_comb begin
        va_ext = PA_W'(vaddr);
        fault  = !(va_ext < bound);
        paddr  = fault ? '0 : (va_ext + base);
    end
endmodule

// File: rtl/bb_outreg.sv
// One-entry response register with a valid/ready handshake.
// Assumes the producer only loads it when accept is high.
module bb_outreg #(
    parameter int PA_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [PA_W-1:0] d_paddr,
    input  logic            d_fault,
    input  logic [1:0]      d_kind,
    input  logic            rsp_ready,
    output logic            q_valid,
    output logic [PA_W-1:0] q_paddr,
    output logic            q_fault,
    output logic [1:0]      q_kind
);
    // Capture on accept, drop when consumed, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_paddr <= '0;
            q_fault <= 1'b0;
            q_kind  <= 2'd0;
        end else if (accept) begin
            q_valid <= 1'b1;
            q_paddr <= d_paddr;
            q_fault <= d_fault;
            q_kind  <= d_kind;
        end else if (rsp_ready) begin
            q_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/bb_xlate.sv
// Base and bound address translator top.
// Relocates virtual addresses of fetches, loads and stores by a base
// register after an unsigned check against a bound register.
// Assumes PA_W >= VA_W. Response latency is one cycle.
module bb_xlate #(
    parameter int VA_W = 16,
    parameter int PA_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [PA_W-1:0] cfg_data,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [1:0]      req_kind,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    output logic [1:0]      rsp_kind,
    output logic            rsp_mem_go
);
    logic [PA_W-1:0] base_q;
    logic [PA_W-1:0] bound_q;
    logic [PA_W-1:0] calc_paddr;
    logic            calc_fault;
    logic            accept;

    bb_regs #(.PA_W(PA_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_data), .base_q(base_q), .bound_q(bound_q)
    );

    bb_calc #(.VA_W(VA_W), .PA_W(PA_W)) i_calc (
        .vaddr(req_vaddr), .base(base_q), .bound(bound_q),
        .paddr(calc_paddr), .fault(calc_fault)
    );

    // Accept when the response slot is empty or being drained.
    always_comb begin
        req_ready = !rsp_valid || rsp_ready;
        accept    = req_valid && req_ready;
    end

    bb_outreg #(.PA_W(PA_W)) i_out (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .d_paddr(calc_paddr), .d_fault(calc_fault), .d_kind(req_kind),
        .rsp_ready(rsp_ready), .q_valid(rsp_valid), .q_paddr(rsp_paddr),
        .q_fault(rsp_fault), .q_kind(rsp_kind)
    );

    // Forward to memory only for a valid, non-faulting response.
    always_comb rsp_mem_go = rsp_valid && !rsp_fault;
endmodule

// File: rtl/bb_xlate_chk.sv
// Port-level assertions for bb_xlate, attached with bind.
module bb_xlate_chk #(
    parameter int PA_W = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_fault,
    input logic [1:0]      rsp_kind,
    input logic            rsp_mem_go
);
    // R6: a fault carries a zero address
    a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R6: memory strobe only for a clean valid response
    a_r6_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mem_go |-> (rsp_valid && !rsp_fault));

    // R8: accepted request appears the next cycle
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R9: a stalled response is held
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready && !req_ready) |=>
        (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_kind)));

    // R9: empty slot always takes a request
    a_r9_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);
endmodule

bind bb_xlate bb_xlate_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_kind(rsp_kind), .rsp_mem_go(rsp_mem_go)
);

// File: tb/test_bb_xlate.sv
module test_bb_xlate;
    localparam int VA_W = 16;
    localparam int PA_W = 20;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_we, cfg_sel;
    logic [PA_W-1:0] cfg_data;
    logic            req_valid, req_ready;
    logic [VA_W-1:0] req_vaddr;
    logic [1:0]      req_kind;
    logic            rsp_valid, rsp_ready;
    logic [PA_W-1:0] rsp_paddr;
    logic            rsp_fault;
    logic [1:0]      rsp_kind;
    logic            rsp_mem_go;

    bb_xlate #(.VA_W(VA_W), .PA_W(PA_W)) i_bb_xlate (.*);

    always #10 clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";

    // behavioural reference state
    int    m_base = 0, m_bound = 0;
    bit    m_valid = 0, m_fault = 0;
    int    m_paddr = 0, m_kind = 0;
    int    cyc = 0;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // Compare every response port against the model (called at negedge).
    task automatic compare_all();
        chk("rsp_valid", int'(rsp_valid), int'(m_valid));
        chk("req_ready", int'(req_ready), int'(!m_valid || rsp_ready));
        chk("rsp_mem_go", int'(rsp_mem_go), int'(m_valid && !m_fault));
        if (m_valid) begin
            chk("rsp_fault", int'(rsp_fault), int'(m_fault));
            chk("rsp_paddr", int'(rsp_paddr), m_paddr);
            chk("rsp_kind", int'(rsp_kind), m_kind);
        end
    endtask

    // Apply inputs at negedge, advance the model, then pass the edge.
    task automatic step(input bit we, input bit sel, input int data,
                        input bit rv, input int va, input int kind, input bit rr);
        bit   rdy;
        int   lim;
        cfg_we = we; cfg_sel = sel; cfg_data = PA_W'(data);
        req_valid = rv; req_vaddr = VA_W'(va); req_kind = 2'(kind);
        rsp_ready = rr;
        #1;
        compare_all();
        rdy = !m_valid || rr;
        if (rv && rdy) begin
            lim = m_bound;
            m_valid = 1;
            m_kind = kind;
            m_fault = !(va < lim);
            m_paddr = m_fault ? 0 : ((va + m_base) % (1 << PA_W));
        end else if (rr) begin
            m_valid = 0;
        end
        if (we) begin
            if (sel) m_bound = data; else m_base = data;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input bit sel, input int data);
        step(1, sel, data, 0, 0, 0, 1);
    endtask

    task automatic rq(input int va, input int kind);
        step(0, 0, 0, 1, va, kind, 1);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #4000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_data = '0;
        req_valid = 0; req_vaddr = '0; req_kind = '0; rsp_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        chk("reset rsp_valid", int'(rsp_valid), 0);
        rst_n = 1;
        // R1 / R4: bound cleared, address 0 faults
        cur_req = "R4";
        rq(0, 1);
        idle();
        // R7: program base and bound
        cur_req = "R7";
        wr(0, 'h1000);
        wr(1, 'h100);
        // R2 legal translations
        cur_req = "R2";
        rq(0, 1); rq('hFF, 1);
        // R3 exactly at and above the limit
        cur_req = "R3";
        rq('h100, 1); rq('hFFFF, 1); rq('hFE, 1);
        // R5 each kind
        cur_req = "R5";
        rq('h10, 0); rq('h20, 2); rq('h30, 3); rq('h200, 2);
        // R6 fault zero address / no forward
        cur_req = "R6";
        rq('h101, 0); idle();
        // R7 write and request same cycle: old values apply
        cur_req = "R7";
        step(1, 1, 'h20, 1, 'h50, 1, 1);
        rq('h50, 1);
        step(1, 0, 'hFFFF0, 1, 'h10, 0, 1);
        rq('h10, 0);
        // R2 wrap at top of physical space
        cur_req = "R2";
        wr(1, 'hFFFFF);
        rq('hFFFF, 1);
        // R9 stall holds response, ready low
        cur_req = "R9";
        step(0, 0, 0, 1, 'h11, 2, 0);
        step(0, 0, 0, 1, 'h22, 1, 0);
        step(0, 0, 0, 1, 'h33, 0, 0);
        step(0, 0, 0, 1, 'h44, 1, 1);
        step(0, 0, 0, 0, 0, 0, 0);
        idle();
        // R8 back-to-back acceptance
        cur_req = "R8";
        rq(1, 1); rq(2, 1); rq(3, 1); idle();
        // R4 zero bound again
        cur_req = "R4";
        wr(1, 0);
        rq(0, 0); rq(5, 2);
        // R3 mixed random traffic
        cur_req = "R3";
        for (int i = 0; i < 400; i++) begin
            int r = $urandom;
            step(r[0] & r[1], r[2], (r[3]) ? (r % 'h300) : ($urandom % (1 << PA_W)),
                 r[4] | r[5], $urandom % 'h400, r[7:6], r[8] | r[9]);
        end
        idle(); idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule